// File: doc/BRIEF.md
# Per-Lane Bit Gather Unit

This block performs a parallel bit extract (bit compress) over a wide vector. A data vector and a mask vector of the same width are cut into equal lanes, and the lane width is picked per operation by a 2-bit size code. In every lane, the data bits that sit under a set mask bit are packed toward bit 0 of that lane. They keep their relative order, and every lane bit above the packed group is driven to zero. Packed bits never spill from one lane into its neighbour.

An operation is issued by raising `in_valid` for one cycle together with the operands and the size code. The result appears on `out_result` with `out_valid` high on the following cycle. Every lane always produces a result, since there is no per-lane enable. Back-to-back operations may be issued on every cycle.

Top module: `bitgather_unit`

## Requirements
- R1: Within a lane, a data bit whose mask bit is 1 appears at result position k, where k is the number of set mask bits below it in that lane.
- R2: Gathered bits keep their order: of two selected bits, the lower-numbered source bit lands in the lower-numbered result bit.
- R3: In each lane, every result bit at a position equal to or above the count of set mask bits in that lane is 0.
- R4: The lane width is 8 shifted left by the size code: code 0 gives 8-bit lanes, 1 gives 16, 2 gives 32 and 3 gives 64. The vector holds VEC_W divided by the lane width lanes, and lane i occupies bits [i*W +: W].
- R5: Each result lane depends only on the same lane of data and mask. No selected bit crosses a lane boundary.
- R6: `out_valid` is high in exactly those cycles that follow a clock edge at which `in_valid` was high. The result is computed from the operands and size code sampled at that edge.
- R7: After an edge at which `in_valid` was low, `out_result` keeps its previous value.
- R8: While `rst_n` is low, `out_valid` and `out_result` are 0, whatever the clock does.
- R9: A mask lane of all zeros yields a zero result lane. A mask lane of all ones yields a copy of the data lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation issue strobe |
| in_size | input | 2 | Lane size code (0: 8, 1: 16, 2: 32, 3: 64 bits) |
| in_data | input | VEC_W | Source data vector |
| in_mask | input | VEC_W | Selection mask vector |
| out_valid | output | 1 | Result valid, one cycle after issue |
| out_result | output | VEC_W | Gathered result vector |

## Verification
With 8-bit lanes, every combination of data byte and mask byte is swept. This catches an off-by-one in the packing position (R1) and a reversed bit order (R2), which would each show up as a misplaced bit. Random operands at all four sizes, together with all-zero, all-ones, alternating and walking single-bit masks, expose three more faults. A lane boundary computed at the wrong place would leak bits into a neighbouring lane. Upper bits left uncleared would appear as stale ones above the packed group. A decoded size code off by one would pack over the wrong width. Idle cycles between issues check that the result is held and that the valid flag does not repeat, and a mid-run reset checks that the outputs clear without a clock edge.

// File: rtl/bitgather_pkg.sv
package bitgather_pkg;

  // Lane size codes: lane width = 8 << code
  typedef enum logic [1:0] {
    LSZ_8  = 2'd0,
    LSZ_16 = 2'd1,
    LSZ_32 = 2'd2,
    LSZ_64 = 2'd3
  } lane_size_e;

  localparam int unsigned NUM_SIZES = 4;
  localparam int unsigned BASE_LANE_W = 8;

  function automatic int unsigned lane_width(input int unsigned code);
    return BASE_LANE_W << code;
  endfunction

endpackage

// File: rtl/bitgather_lane.sv
module bitgather_lane #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] lane_data,
  input  logic [W-1:0] lane_mask,
  output logic [W-1:0] lane_res
);

  localparam int unsigned IW = $clog2(W);

  logic [W-1:0] res_c;
  logic [IW:0]  pos_c;

  // Walk the lane from bit 0 upward; each selected bit goes to the next free slot.
  always_comb begin
    res_c = '0;
    pos_c = '0;
    for (int i = 0; i < int'(W); i++) begin
      if (lane_mask[i]) begin
        res_c[pos_c[IW-1:0]] = lane_data[i];
        pos_c = pos_c + 1'b1;
      end
    end
  end

  assign lane_res = res_c;

  // Lane-local checks on the packed output
  always_comb begin
    if (lane_mask == '0)
      assert_zero_mask_R9: assert (lane_res == '0);
    if (lane_mask == '1)
      assert_full_mask_R9: assert (lane_res == lane_data);
    assert_no_extra_ones_R3: assert ($countones(lane_res) <= $countones(lane_data & lane_mask));
  end

endmodule

// File: rtl/bitgather_span.sv
module bitgather_span #(
  parameter int unsigned VEC_W  = 128,
  parameter int unsigned LANE_W = 8
) (
  input  logic [VEC_W-1:0] span_data,
  input  logic [VEC_W-1:0] span_mask,
  output logic [VEC_W-1:0] span_res
);

  localparam int unsigned NUM_LANES = VEC_W / LANE_W;

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    bitgather_lane #(
      .W (LANE_W)
    ) lane_i (
      .lane_data (span_data[g*LANE_W +: LANE_W]),
      .lane_mask (span_mask[g*LANE_W +: LANE_W]),
      .lane_res  (span_res [g*LANE_W +: LANE_W])
    );
  end

endmodule

// File: rtl/bitgather_unit.sv
module bitgather_unit
  import bitgather_pkg::*;
#(
  parameter int unsigned VEC_W = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [1:0]       in_size,
  input  logic [VEC_W-1:0] in_data,
  input  logic [VEC_W-1:0] in_mask,
  output logic             out_valid,
  output logic [VEC_W-1:0] out_result
);

  logic [VEC_W-1:0] size_res [NUM_SIZES];

  // One lane array per size; the size code picks one of them.
  for (genvar s = 0; s < NUM_SIZES; s++) begin : g_size
    bitgather_span #(
      .VEC_W  (VEC_W),
      .LANE_W (lane_width(s))
    ) span_i (
      .span_data (in_data),
      .span_mask (in_mask),
      .span_res  (size_res[s])
    );
  end

  lane_size_e       size_sel;
  logic [VEC_W-1:0] gathered;
  logic             res_en;
  logic [VEC_W-1:0] res_d, res_q;
  logic             vld_d, vld_q;

  assign size_sel = lane_size_e'(in_size);

  always_comb begin
    unique case (size_sel)
      LSZ_8:   gathered = size_res[0];
      LSZ_16:  gathered = size_res[1];
      LSZ_32:  gathered = size_res[2];
      default: gathered = size_res[3];
    endcase
  end

  // Next state
  assign res_en = in_valid;
  always_comb begin
    res_d = res_q;
    if (res_en) res_d = gathered;
    vld_d = in_valid;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
      if (res_en) res_q <= res_d;
    end
  end

  assign out_valid  = vld_q;
  assign out_result = res_q;

  assert_valid_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_valid_drops_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  assert_result_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_result));
  assert_zero_mask_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_mask == '0) |=> out_result == '0);

endmodule

// File: tb/bitgather_unit_tb_top.sv
module bitgather_unit_tb_top;

  localparam int unsigned VW = 128;

  logic          clk;
  logic          rst_n;
  logic          in_valid;
  logic [1:0]    in_size;
  logic [VW-1:0] in_data;
  logic [VW-1:0] in_mask;
  logic          out_valid;
  logic [VW-1:0] out_result;

  bitgather_unit #(.VEC_W(VW)) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_size    (in_size),
    .in_data    (in_data),
    .in_mask    (in_mask),
    .out_valid  (out_valid),
    .out_result (out_result)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int unsigned   n_cmp = 0;
  int unsigned   n_bad = 0;
  logic          pend_v = 1'b0;
  logic [VW-1:0] exp_res = '0;
  string         pend_tag = "R8";
  bit            finished = 1'b0;

  // Behavioural reference: lane width 8<<size, selected bits packed from bit 0
  function automatic logic [VW-1:0] ref_gather(input logic [1:0] sz,
                                               input logic [VW-1:0] d,
                                               input logic [VW-1:0] m);
    int lw;
    int k;
    logic [VW-1:0] r;
    lw = 8 << sz;
    r = '0;
    for (int base = 0; base < VW; base += lw) begin
      k = 0;
      for (int i = 0; i < lw; i++) begin
        if (m[base+i]) begin
          r[base+k] = d[base+i];
          k++;
        end
      end
    end
    return r;
  endfunction

  function automatic logic [VW-1:0] rnd_vec();
    logic [VW-1:0] v;
    for (int w = 0; w < VW/32; w++) v[w*32 +: 32] = $urandom();
    return v;
  endfunction

  task automatic report();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    finished = 1'b1;
    $finish;
  endtask

  // Check the previous issue, then drive the next one
  task automatic step(input logic v, input logic [1:0] sz,
                      input logic [VW-1:0] d, input logic [VW-1:0] m,
                      input string tag);
    @(negedge clk);
    n_cmp++;
    if (out_valid !== pend_v || out_result !== exp_res) begin
      n_bad++;
      $display("FAIL %s: valid=%0b result=%h expected valid=%0b result=%h",
               pend_tag, out_valid, out_result, pend_v, exp_res);
    end
    in_valid = v;
    in_size  = sz;
    in_data  = d;
    in_mask  = m;
    if (v) exp_res = ref_gather(sz, d, m);
    pend_v   = v;
    pend_tag = tag;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: valid=%0b result=%h expected valid=%0b result=%h",
               out_valid, out_result, pend_v, exp_res);
      report();
    end
  end

  initial begin
    logic [VW-1:0] d, m;
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_size  = 2'd0;
    in_data  = '0;
    in_mask  = '0;
    repeat (3) @(negedge clk);
    // R8: reset state
    n_cmp++;
    if (out_valid !== 1'b0 || out_result !== '0) begin
      n_bad++;
      $display("FAIL R8 reset: valid=%0b result=%h expected valid=0 result=0",
               out_valid, out_result);
    end
    rst_n = 1'b1;

    // R1 R2 R3: all data/mask byte pairs with 8-bit lanes
    for (int mi = 0; mi < 256; mi++) begin
      for (int di = 0; di < 256; di++) begin
        for (int k = 0; k < VW/8; k++) begin
          d[k*8 +: 8] = 8'(di ^ (k*29));
          m[k*8 +: 8] = 8'(mi);
        end
        step(1'b1, 2'd0, d, m, "R1_R2_R3 byte sweep");
      end
    end

    // R4 R5: random operands at every size, idle gaps check R6 R7
    for (int sz = 0; sz < 4; sz++) begin
      for (int t = 0; t < 400; t++) begin
        step(1'b1, 2'(sz), rnd_vec(), rnd_vec(), "R4_R5 random");
        if (t % 7 == 0) step(1'b0, 2'(sz ^ 1), rnd_vec(), rnd_vec(), "R6_R7 idle");
      end
    end

    // R9 and corner masks at every size
    for (int sz = 0; sz < 4; sz++) begin
      step(1'b1, 2'(sz), rnd_vec(), '0, "R9 zero mask");
      step(1'b1, 2'(sz), rnd_vec(), '1, "R9 full mask");
      step(1'b1, 2'(sz), rnd_vec(), {(VW/4){4'h5}}, "R3 alternating 5");
      step(1'b1, 2'(sz), rnd_vec(), {(VW/4){4'hA}}, "R3 alternating A");
      for (int b = 0; b < VW; b++) begin
        m = '0;
        m[b] = 1'b1;
        step(1'b1, 2'(sz), rnd_vec(), m, "R1_R5 single bit");
        step(1'b1, 2'(sz), '1, m, "R1_R5 single bit ones");
      end
    end

    // R8: asynchronous reset mid-run
    step(1'b1, 2'd3, '1, '1, "R9 full before reset");
    step(1'b0, 2'd0, '0, '0, "R7 hold before reset");
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    n_cmp++;
    if (out_valid !== 1'b0 || out_result !== '0) begin
      n_bad++;
      $display("FAIL R8 async reset: valid=%0b result=%h expected valid=0 result=0",
               out_valid, out_result);
    end
    @(negedge clk);
    rst_n = 1'b1;
    exp_res  = '0;
    pend_v   = 1'b0;
    pend_tag = "R8 after reset";
    step(1'b1, 2'd1, rnd_vec(), rnd_vec(), "R6 after reset");
    step(1'b0, 2'd0, '0, '0, "R7 final");
    step(1'b0, 2'd0, '0, '0, "R7 final");
    report();
  end

endmodule